// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous host to an asynchronous static memory that is 32 bits wide, with 19 address bits. It has no clock of its own on the memory side. Each 8-bit byte lane of the memory has its own active-low select. The three control lines are the per-lane selects, a shared write strobe and a shared output enable. The host gives a one-cycle start pulse together with the address, the write data, a 4-bit lane mask and a write flag. The controller then runs the whole memory cycle and pulses `req_done` when it finishes. For a read, the captured word is then on `rd_data`.

Every phase of a memory cycle lasts a whole number of clock cycles, and each phase length is a parameter. Each length is the nanosecond minimum rounded up at the chosen clock period, with a floor of one cycle. With a 125 MHz clock the phases are:
- address/data setup: 1 cycle
- write strobe: 2 cycles (16 ns against 14 ns, which also covers the 10 ns data overlap)
- recovery: 1 cycle
- read access: 3 cycles (24 ns against 20 ns)
- bus float: 1 cycle (8 ns against 5 ns)

During a write the output enable is held high for the whole cycle, so the shorter strobe minimum applies. The controller drives the shared data bus only while the memory's outputs are off.

The state machine has six states:
- `ST_IDLE`: waits for a start pulse.
- `ST_WR_FLOAT`: output enable high, drivers off, no lane selected.
- `ST_WR_SETUP`: masked lanes selected, drivers on.
- `ST_WR_PULSE`: write strobe low.
- `ST_WR_RECOV`: strobe and selects released, data still driven.
- `ST_RD_ACCESS`: all lanes selected, output enable low.

The transitions are:
- IDLE→WR_FLOAT: a write is accepted while a read has left the bus to float.
- IDLE→WR_SETUP: any other accepted write.
- IDLE→RD_ACCESS: a read is accepted.
- FLOAT→SETUP, SETUP→PULSE, PULSE→RECOV, RECOV→IDLE and ACCESS→IDLE: each taken when the phase timer expires.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is active, all four lane selects, the write strobe and the output enable are high, the data drivers are off and `req_done` is low.
- R2: A write selects exactly the lanes whose mask bit is 1 (mask bit i gates data bits 8i+7..8i on `mem_dq_out`). It holds `mem_we_n` low for exactly T_STROBE cycles, and the data is written into those lanes only.
- R3: `mem_oe_n` is high during every cycle in which `mem_we_n` is low.
- R4: The data drivers are on for every cycle of the write strobe and never while `mem_oe_n` is low. Write data does not change while the strobe is low.
- R5: A read selects all four lanes, pulls `mem_oe_n` low for exactly T_ACCESS cycles with the strobe high and the drivers off, and presents the full 32-bit word on `rd_data`.
- R6: `req_done` is high for exactly one cycle per accepted request. It rises T_ACCESS edges after the accepting edge for a read, and T_SETUP+T_STROBE+T_RECOV edges after it for a write (plus T_TURN when the R8 float applies).
- R7: A start pulse given while the controller is not idle is ignored. It produces no extra `req_done` and writes nothing.
- R8: The first write after a read spends T_TURN cycles with output enable high, drivers off and no lane selected before the drivers turn on. A write that follows a write turns its drivers on in the first cycle after acceptance.
- R9: `rd_data` keeps the last read word until the next read completes, including across writes.
- R10: `mem_addr` holds the accepted address, unchanged, for as long as any lane select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request strobe, taken only in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Lane mask for writes, bit i = byte lane i |
| req_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Last word read |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 4 | Active-low per-lane selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 32 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 32 | Data returned by the memory |

## Verification
All memory-side outputs are registered from the next state, so they change on the accepting edge and on each phase edge. `req_done` rises T_ACCESS edges after acceptance for a read, and T_SETUP+T_STROBE+T_RECOV edges (plus T_TURN after a read) for a write; `rd_data` is valid on that same edge. The bench drives its inputs on falling edges and also samples on falling edges. It counts falling edges from the accepting edge, so a done pulse due L edges after acceptance is expected at falling edge L+1. Strobe widths, lane patterns and the first-cycle driver state are tallied at every one of those samples.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_FLOAT,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_ACCESS
    } ctl_state_e;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // A phase of n cycles is loaded with n-1 and ends when the count is zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_nx,
    input  logic         load_wr,
    input  logic [W-1:0] wr_byte,
    input  logic         capture,
    input  logic [W-1:0] dq_in,
    output logic         cs_n,
    output logic [W-1:0] dq_out,
    output logic [W-1:0] rd_byte
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n    <= 1'b1;
            dq_out  <= '0;
            rd_byte <= '0;
        end else begin
            cs_n <= ~sel_nx;
            if (load_wr) begin
                dq_out <= wr_byte;
            end
            if (capture) begin
                rd_byte <= dq_in;
            end
        end
    end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter  int ADDR_W   = 19,
    parameter  int LANES    = 4,
    parameter  int LANE_W   = 8,
    parameter  int T_SETUP  = 1,
    parameter  int T_STROBE = 2,
    parameter  int T_RECOV  = 1,
    parameter  int T_ACCESS = 3,
    parameter  int T_TURN   = 1,
    localparam int DATA_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int MAX_A  = (T_SETUP > T_STROBE) ? T_SETUP : T_STROBE;
    localparam int MAX_B  = (T_RECOV > T_ACCESS) ? T_RECOV : T_ACCESS;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_PH = (MAX_C > T_TURN) ? MAX_C : T_TURN;
    localparam int CNT_W  = $clog2(MAX_PH) + 1;

    ctl_state_e       state_q;
    ctl_state_e       state_nx;
    logic             accept;
    logic             expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             capture;
    logic             float_pend_q;
    logic [LANES-1:0] mask_q;
    logic [LANES-1:0] mask_nx;
    logic [LANES-1:0] lane_sel_nx;
    logic             wr_sel_nx;

    assign accept  = (state_q == ST_IDLE) && req_start;
    assign capture = (state_q == ST_RD_ACCESS) && expired;
    assign mask_nx = accept ? req_mask : mask_q;

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        state_nx = float_pend_q ? ST_WR_FLOAT : ST_WR_SETUP;
                    end else begin
                        state_nx = ST_RD_ACCESS;
                    end
                end
            end
            ST_WR_FLOAT:  if (expired) state_nx = ST_WR_SETUP;
            ST_WR_SETUP:  if (expired) state_nx = ST_WR_PULSE;
            ST_WR_PULSE:  if (expired) state_nx = ST_WR_RECOV;
            ST_WR_RECOV:  if (expired) state_nx = ST_IDLE;
            ST_RD_ACCESS: if (expired) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Phase length of the state being entered.
    always_comb begin
        tmr_load = (state_nx != state_q);
        unique case (state_nx)
            ST_WR_FLOAT:  tmr_val = CNT_W'(T_TURN - 1);
            ST_WR_SETUP:  tmr_val = CNT_W'(T_SETUP - 1);
            ST_WR_PULSE:  tmr_val = CNT_W'(T_STROBE - 1);
            ST_WR_RECOV:  tmr_val = CNT_W'(T_RECOV - 1);
            ST_RD_ACCESS: tmr_val = CNT_W'(T_ACCESS - 1);
            default:      tmr_val = '0;
        endcase
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Registered outputs, decoded from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr     <= '0;
            mem_we_n     <= 1'b1;
            mem_oe_n     <= 1'b1;
            mem_dq_oe    <= 1'b0;
            req_done     <= 1'b0;
            float_pend_q <= 1'b0;
            mask_q       <= '0;
        end else begin
            mask_q    <= mask_nx;
            if (accept) begin
                mem_addr <= req_addr;
            end
            mem_we_n  <= (state_nx != ST_WR_PULSE);
            mem_oe_n  <= (state_nx != ST_RD_ACCESS);
            mem_dq_oe <= (state_nx == ST_WR_SETUP) || (state_nx == ST_WR_PULSE)
                      || (state_nx == ST_WR_RECOV);
            req_done  <= (state_nx == ST_IDLE) && (state_q != ST_IDLE);
            if (capture) begin
                float_pend_q <= 1'b1;
            end else if (state_nx == ST_WR_FLOAT) begin
                float_pend_q <= 1'b0;
            end
        end
    end

    assign wr_sel_nx = (state_nx == ST_WR_SETUP) || (state_nx == ST_WR_PULSE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_sel_nx[g] = (wr_sel_nx && mask_nx[g]) || (state_nx == ST_RD_ACCESS);

        sram_lane #(.W(LANE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_nx  (lane_sel_nx[g]),
            .load_wr (accept && req_write),
            .wr_byte (req_wdata[g*LANE_W +: LANE_W]),
            .capture (capture),
            .dq_in   (mem_dq_in[g*LANE_W +: LANE_W]),
            .cs_n    (mem_cs_n[g]),
            .dq_out  (mem_dq_out[g*LANE_W +: LANE_W]),
            .rd_byte (rd_data[g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W   = 19,
    parameter int LANES    = 4,
    parameter int DATA_W   = 32,
    parameter int T_STROBE = 2,
    parameter int T_TURN   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    int we_low_cnt;
    int oe_high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt  <= 0;
            oe_high_cnt <= 255;
        end else begin
            we_low_cnt  <= !mem_we_n ? ((we_low_cnt < 255) ? we_low_cnt + 1 : 255) : 0;
            oe_high_cnt <= mem_oe_n ? ((oe_high_cnt < 255) ? oe_high_cnt + 1 : 255) : 0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (&mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_done));

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == T_STROBE));

    assert_oe_high_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_drive_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_out));

    assert_read_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_cs_n == '0 && mem_we_n && !mem_dq_oe));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    assert_float_before_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_high_cnt >= T_TURN));

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_cs_n) && !(&$past(mem_cs_n))) |-> $stable(mem_addr));

endmodule

bind async_sram_ctrl sram_ctrl_checker #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .DATA_W   (DATA_W),
    .T_STROBE (T_STROBE),
    .T_TURN   (T_TURN)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_done   (req_done),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;

    localparam int TS = 1;
    localparam int TP = 2;
    localparam int TR = 1;
    localparam int TA = 3;
    localparam int TT = 1;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  mask;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h10, 32'h11223344, 4'hF, 32'h0},
        '{1'b1, 8'h20, 32'hAABBCCDD, 4'hF, 32'h0},
        '{1'b0, 8'h10, 32'h0,        4'h0, 32'h11223344},
        '{1'b1, 8'h10, 32'h55667788, 4'h5, 32'h0},
        '{1'b0, 8'h10, 32'h0,        4'h0, 32'h11663388},
        '{1'b0, 8'h20, 32'h0,        4'h0, 32'hAABBCCDD},
        '{1'b1, 8'h20, 32'hFFFFFFFF, 4'h0, 32'h0},
        '{1'b0, 8'h20, 32'h0,        4'h0, 32'hAABBCCDD},
        '{1'b1, 8'hFF, 32'h0F0F0F0F, 4'hA, 32'h0},
        '{1'b0, 8'hFF, 32'h0,        4'h0, 32'h0F000F00},
        '{1'b0, 8'h00, 32'h0,        4'h0, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        req_done;
    logic [31:0] rd_data;
    logic [18:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [31:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_in;

    int  nchk = 0;
    int  nfail = 0;
    int  cyc = 0;
    bit  prev_read = 1'b0;
    logic [31:0] mem_model [256];

    always #4 clk = ~clk;

    async_sram_ctrl #(
        .T_SETUP(TS), .T_STROBE(TP), .T_RECOV(TR), .T_ACCESS(TA), .T_TURN(TT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_done(req_done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory: lanes write while selected and strobed, read while output-enabled.
    always @(negedge clk) begin
        if (rst_n && !mem_we_n && mem_dq_oe) begin
            for (int b = 0; b < 4; b++) begin
                if (!mem_cs_n[b]) mem_model[mem_addr[7:0]][8*b +: 8] <= mem_dq_out[8*b +: 8];
            end
        end
    end

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            mem_dq_in[8*b +: 8] = (!mem_oe_n && !mem_cs_n[b] && mem_we_n)
                                ? mem_model[mem_addr[7:0]][8*b +: 8] : 8'hA5;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [7:0] a, input logic [31:0] d,
                         input logic [3:0] m, input bit poke_busy);
        int n = 0;
        int we_cnt = 0;
        int oe_cnt = 0;
        int bad_oe = 0;
        int bad_rd = 0;
        int bad_addr = 0;
        logic [3:0] cs_seen = 4'hF;
        logic first_oe = 1'b0;
        logic [3:0] first_cs = 4'h0;
        bit float_exp = wr && prev_read;
        int lat = wr ? (TS + TP + TR + (float_exp ? TT : 0)) : TA;
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = {11'b0, a};
        req_wdata = d; req_mask = m;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_start = 1'b0;
                first_oe = mem_dq_oe;
                first_cs = mem_cs_n;
            end
            if (poke_busy && n == 2) begin
                req_start = 1'b1; req_write = 1'b1; req_addr = 19'h31;
                req_wdata = 32'hCAFEF00D; req_mask = 4'hF;
            end
            if (poke_busy && n == 3) req_start = 1'b0;
            if (!mem_we_n) begin
                we_cnt++;
                cs_seen = mem_cs_n;
                if (!mem_oe_n) bad_oe++;
            end
            if (!mem_oe_n) begin
                oe_cnt++;
                if (mem_cs_n != 4'h0 || mem_dq_oe) bad_rd++;
            end
            if (!(&mem_cs_n) && mem_addr != {11'b0, a}) bad_addr++;
            if (req_done || n > 60) break;
        end
        chk("R6 latency", n - 1, lat);
        chk("R10 address held", bad_addr, 0);
        if (wr) begin
            chk("R2 strobe cycles", we_cnt, TP);
            if (m != 4'h0) chk("R2 lane selects", {28'b0, cs_seen}, {28'b0, ~m});
            chk("R3 oe high in write", bad_oe, 0);
            chk("R8 first-cycle drivers", {31'b0, first_oe}, {31'b0, !float_exp});
            if (float_exp) chk("R8 float selects", {28'b0, first_cs}, 32'hF);
        end else begin
            chk("R5 access cycles", oe_cnt, TA);
            chk("R5 all lanes, drivers off", bad_rd, 0);
        end
        @(negedge clk);
        chk("R6 done one cycle", {31'b0, req_done}, 32'h0);
        prev_read = !wr;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_model[i] = 32'h0;
        repeat (3) @(negedge clk);
        chk("R1 selects", {28'b0, mem_cs_n}, 32'hF);
        chk("R1 strobes", {30'b0, mem_we_n, mem_oe_n}, 32'h3);
        chk("R1 drivers/done", {30'b0, mem_dq_oe, req_done}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            do_op(VEC[v].wr, VEC[v].addr, VEC[v].data, VEC[v].mask, 1'b0);
            if (!VEC[v].wr) chk("R5/R2 read data", rd_data, VEC[v].exp);
        end

        // R7: start pulse during a busy write is dropped.
        do_op(1'b1, 8'h30, 32'h12345678, 4'hF, 1'b1);
        begin
            int extra = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (req_done) extra++;
            end
            chk("R7 no extra done", extra, 0);
        end
        do_op(1'b0, 8'h31, 32'h0, 4'h0, 1'b0);
        chk("R7 busy write dropped", rd_data, 32'h0);
        do_op(1'b0, 8'h30, 32'h0, 4'h0, 1'b0);
        chk("R2 full write", rd_data, 32'h12345678);

        // R9: read result survives a following write.
        do_op(1'b1, 8'h40, 32'h00000001, 4'hF, 1'b0);
        chk("R9 rd_data held", rd_data, 32'h12345678);
        do_op(1'b1, 8'h41, 32'h00000002, 4'hF, 1'b0);
        chk("R9 rd_data held twice", rd_data, 32'h12345678);

        summary();
        $finish;
    end

endmodule